// File: doc/BRIEF.md
# Bandwidth Allocation Control Registers

This block is the software-facing register set of a memory-bandwidth controller. For every resource-control ID (RCID) it keeps two settings. The first is a count of reserved bandwidth blocks. The second is an 8-bit weight that sets the RCID's share of whatever bandwidth is not reserved. Software never touches that per-RCID storage directly. It edits one shared staging register and then writes a command that names an RCID. A load command copies the RCID's stored settings into staging. A commit command copies staging into the RCID's storage.

Each command runs for a fixed, parameterised number of cycles. A busy flag is set for that whole time. When the command completes, a status code reports the outcome. A commit is refused if it would make the reserved counts of all RCIDs add up to more than the reserve limit in the capabilities register. The monitoring registers are present but report that monitoring is unsupported.

The command machine has three states. `ST_IDLE` accepts a command write and moves to `ST_WAIT`. `ST_WAIT` counts down the busy window and moves to `ST_EXEC` when the count reaches zero. `ST_EXEC` applies the command, posts its status and returns to `ST_IDLE`.

Top module: `bw_alloc_regs`

## Requirements
- R1: The word at byte offset 0 is read-only and holds these fields: minor version in bits 3:0, major version in bits 7:4, total bandwidth blocks in bits 23:8 and the reserve limit in bits 47:32. All other bits read 0.
- R2: After reset, the control word (offset 24) and the staging word (offset 32) read 0. RCID 0 holds a reserved count equal to the reserve limit minus (number of RCIDs minus 1). Every other RCID holds 1. Every weight holds the default value of 8.
- R3: The staging word holds the reserved count in bits 15:0 and the weight in bits 27:20, and reads 0 elsewhere. Writing the control word with opcode 1 (bits 4:0) and an RCID (bits 19:8) stores both staging fields for that RCID and posts status 1 (bits 38:32).
- R4: Opcode 2 overwrites both staging fields with the RCID's stored values, whatever staging held before, and posts status 1.
- R5: An accepted command holds busy (bit 39) at 1 for exactly BUSY_CYCLES cycles. The status field reads 0 during that time. The final status is visible in the cycle in which busy clears.
- R6: A write to the control word while busy is 1 is ignored. The opcode and RCID fields in the control word keep their values, and no storage changes.
- R7: An opcode other than 1 or 2 completes with status 2 and leaves storage unchanged. The opcode is checked before the RCID.
- R8: An RCID equal to or above NUM_RCID completes with status 3 and leaves storage unchanged.
- R9: A commit that would bring the sum of reserved counts above the reserve limit completes with status 4 and leaves storage unchanged. A commit that brings the sum exactly to the limit succeeds.
- R10: The monitor control word (offset 8) always reads status 2 in bits 38:32 and 0 elsewhere. The monitor value word (offset 16) reads 0. Writes to either have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 6 | Byte address of the 64-bit word |
| wdata | input | 64 | Write data |
| rdata | output | 64 | Read data for `addr` (combinational) |

## Verification
The embedded assertions check several properties on every cycle. The running reserved total must always equal a fresh sum over all RCIDs and never exceed the limit. Busy must last at least two cycles and always end with a nonzero status. A control write during busy must leave the latched command unchanged. A commit must only reach storage for an in-range RCID. A load must fill staging with the values stored for the addressed RCID. Only the bench's scenarios can show the rest: the exact busy length, the particular status code chosen for each fault, and the seeded reset values. The bench's scenarios also show that a read-modify-commit of one field keeps the other field, and that a sentinel left in staging is replaced by a load.

// File: rtl/bwa_pkg.sv
package bwa_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_WAIT = 2'd1,
        ST_EXEC = 2'd2
    } cmd_state_t;

    // command opcodes
    localparam logic [4:0] OP_COMMIT = 5'd1;
    localparam logic [4:0] OP_LOAD   = 5'd2;

    // completion codes
    localparam logic [6:0] STAT_NONE   = 7'd0;
    localparam logic [6:0] STAT_OK     = 7'd1;
    localparam logic [6:0] STAT_BAD_OP = 7'd2;
    localparam logic [6:0] STAT_BAD_ID = 7'd3;
    localparam logic [6:0] STAT_OVER   = 7'd4;

    // word index = byte address / 8
    localparam logic [2:0] W_CAPS    = 3'd0;
    localparam logic [2:0] W_MON_CTL = 3'd1;
    localparam logic [2:0] W_MON_VAL = 3'd2;
    localparam logic [2:0] W_ALLOC   = 3'd3;
    localparam logic [2:0] W_STAGE   = 3'd4;

    // field widths fixed by the register layout
    localparam int RES_W  = 16;
    localparam int WT_W   = 8;
    localparam int ID_W   = 12;
    localparam int WT_LSB = 20;

endpackage

// File: rtl/bwa_store.sv
module bwa_store
    import bwa_pkg::*;
#(
    parameter int NUM_RCID   = 16,
    parameter int MAX_RES    = 64,
    parameter int WT_DEFAULT = 8,
    parameter int IDX_W      = 4,
    parameter int TOT_W      = 21
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [RES_W-1:0] rd_res,
    output logic [WT_W-1:0]  rd_wt,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [RES_W-1:0] wr_res,
    input  logic [WT_W-1:0]  wr_wt,
    output logic [TOT_W-1:0] total
);

    localparam logic [RES_W-1:0] SEED0   = RES_W'(MAX_RES - (NUM_RCID - 1));
    localparam logic [RES_W-1:0] SEED_N  = RES_W'(1);
    localparam logic [WT_W-1:0]  SEED_WT = WT_W'(WT_DEFAULT);

    logic [RES_W-1:0] res_q [NUM_RCID];
    logic [WT_W-1:0]  wt_q  [NUM_RCID];
    logic [TOT_W-1:0] total_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_RCID; i++) begin
                res_q[i] <= (i == 0) ? SEED0 : SEED_N;
                wt_q[i]  <= SEED_WT;
            end
            total_q <= TOT_W'(MAX_RES);
        end else if (wr_en) begin
            res_q[wr_idx] <= wr_res;
            wt_q[wr_idx]  <= wr_wt;
            total_q <= total_q - TOT_W'(res_q[wr_idx]) + TOT_W'(wr_res);
        end
    end

    always_comb begin
        rd_res = res_q[rd_idx];
        rd_wt  = wt_q[rd_idx];
        total  = total_q;
    end

    // independent recount of the reserved total
    logic [TOT_W-1:0] sum_chk;
    always_comb begin
        sum_chk = '0;
        for (int i = 0; i < NUM_RCID; i++) sum_chk = sum_chk + TOT_W'(res_q[i]);
    end

    a_r9_total_tracks: assert property (@(posedge clk) disable iff (!rst_n)
        total_q == sum_chk);
    a_r9_total_capped: assert property (@(posedge clk) disable iff (!rst_n)
        total_q <= TOT_W'(MAX_RES));

endmodule

// File: rtl/bwa_cmd_fsm.sv
module bwa_cmd_fsm
    import bwa_pkg::*;
#(
    parameter int NUM_RCID    = 16,
    parameter int MAX_RES     = 64,
    parameter int BUSY_CYCLES = 3,
    parameter int TOT_W       = 21
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_wr,
    input  logic [4:0]       cmd_op,
    input  logic [2:0]       cmd_at,
    input  logic [ID_W-1:0]  cmd_rcid,
    input  logic [RES_W-1:0] cur_res,
    input  logic [RES_W-1:0] stg_res,
    input  logic [TOT_W-1:0] total,
    output logic             busy,
    output logic [4:0]       op_q,
    output logic [2:0]       at_q,
    output logic [ID_W-1:0]  rcid_q,
    output logic [6:0]       status_q,
    output logic             commit_en,
    output logic             load_en
);

    localparam int CNT_W = (BUSY_CYCLES > 2) ? $clog2(BUSY_CYCLES) : 1;
    localparam logic [CNT_W-1:0] CNT_INIT = CNT_W'(BUSY_CYCLES - 2);

    cmd_state_t       state_q;
    logic [CNT_W-1:0] cnt_q;
    logic [6:0]       verdict;
    logic [TOT_W-1:0] new_total;

    // outcome of the latched command, checked in priority order
    always_comb begin
        new_total = total - TOT_W'(cur_res) + TOT_W'(stg_res);
        if (op_q != OP_COMMIT && op_q != OP_LOAD)
            verdict = STAT_BAD_OP;
        else if (rcid_q >= ID_W'(NUM_RCID))
            verdict = STAT_BAD_ID;
        else if (op_q == OP_COMMIT && new_total > TOT_W'(MAX_RES))
            verdict = STAT_OVER;
        else
            verdict = STAT_OK;
    end

    // state register and latched command
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            cnt_q    <= '0;
            op_q     <= '0;
            at_q     <= '0;
            rcid_q   <= '0;
            status_q <= STAT_NONE;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (cmd_wr) begin
                        op_q     <= cmd_op;
                        at_q     <= cmd_at;
                        rcid_q   <= cmd_rcid;
                        status_q <= STAT_NONE;
                        cnt_q    <= CNT_INIT;
                        state_q  <= ST_WAIT;
                    end
                end
                ST_WAIT: begin
                    if (cnt_q == '0) state_q <= ST_EXEC;
                    else             cnt_q   <= cnt_q - 1'b1;
                end
                ST_EXEC: begin
                    status_q <= verdict;
                    state_q  <= ST_IDLE;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // outputs
    always_comb begin
        busy      = (state_q != ST_IDLE);
        commit_en = (state_q == ST_EXEC) && (verdict == STAT_OK) && (op_q == OP_COMMIT);
        load_en   = (state_q == ST_EXEC) && (verdict == STAT_OK) && (op_q == OP_LOAD);
    end

    a_r5_busy_min_two: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |=> busy);
    a_r5_status_posted: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (status_q != STAT_NONE));
    a_r6_busy_ignores_write: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wr && busy) |=> ($stable(rcid_q) && $stable(op_q)));
    a_r8_commit_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        commit_en |-> (rcid_q < ID_W'(NUM_RCID)));

endmodule

// File: rtl/bw_alloc_regs.sv
module bw_alloc_regs
    import bwa_pkg::*;
#(
    parameter int NUM_RCID    = 16,
    parameter int TOTAL_BLKS  = 256,
    parameter int MAX_RES     = 64,
    parameter int WT_DEFAULT  = 8,
    parameter int BUSY_CYCLES = 3,
    parameter int VER_MAJOR   = 1,
    parameter int VER_MINOR   = 0
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic [5:0]  addr,
    input  logic [63:0] wdata,
    output logic [63:0] rdata
);

    localparam int IDX_W = $clog2(NUM_RCID);
    localparam int TOT_W = RES_W + IDX_W + 1;
    localparam logic [63:0] CAPS_WORD = {16'd0, 16'(MAX_RES), 8'd0,
                                         16'(TOTAL_BLKS), 4'(VER_MAJOR), 4'(VER_MINOR)};
    localparam logic [63:0] MON_WORD  = {25'd0, STAT_BAD_OP, 32'd0};

    logic [2:0]       word;
    logic             cmd_wr;
    logic             busy, commit_en, load_en;
    logic [4:0]       op_q;
    logic [2:0]       at_q;
    logic [ID_W-1:0]  rcid_q;
    logic [6:0]       status_q;
    logic [RES_W-1:0] cur_res, stg_res_q;
    logic [WT_W-1:0]  cur_wt, stg_wt_q;
    logic [TOT_W-1:0] total;

    wire unused_bits = ^{wdata[63:28], addr[2:0]};

    assign word   = addr[5:3];
    assign cmd_wr = wr_en && (word == W_ALLOC);

    bwa_cmd_fsm #(
        .NUM_RCID(NUM_RCID), .MAX_RES(MAX_RES),
        .BUSY_CYCLES(BUSY_CYCLES), .TOT_W(TOT_W)
    ) u_fsm (
        .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr),
        .cmd_op(wdata[4:0]), .cmd_at(wdata[7:5]), .cmd_rcid(wdata[19:8]),
        .cur_res(cur_res), .stg_res(stg_res_q), .total(total),
        .busy(busy), .op_q(op_q), .at_q(at_q), .rcid_q(rcid_q),
        .status_q(status_q), .commit_en(commit_en), .load_en(load_en)
    );

    bwa_store #(
        .NUM_RCID(NUM_RCID), .MAX_RES(MAX_RES), .WT_DEFAULT(WT_DEFAULT),
        .IDX_W(IDX_W), .TOT_W(TOT_W)
    ) u_store (
        .clk(clk), .rst_n(rst_n),
        .rd_idx(rcid_q[IDX_W-1:0]), .rd_res(cur_res), .rd_wt(cur_wt),
        .wr_en(commit_en), .wr_idx(rcid_q[IDX_W-1:0]),
        .wr_res(stg_res_q), .wr_wt(stg_wt_q), .total(total)
    );

    // staging word: a load from storage wins over a software write
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stg_res_q <= '0;
            stg_wt_q  <= '0;
        end else if (load_en) begin
            stg_res_q <= cur_res;
            stg_wt_q  <= cur_wt;
        end else if (wr_en && word == W_STAGE) begin
            stg_res_q <= wdata[RES_W-1:0];
            stg_wt_q  <= wdata[WT_LSB +: WT_W];
        end
    end

    always_comb begin
        case (word)
            W_CAPS:    rdata = CAPS_WORD;
            W_MON_CTL: rdata = MON_WORD;
            W_MON_VAL: rdata = '0;
            W_ALLOC:   rdata = {24'd0, busy, status_q, 12'd0, rcid_q, at_q, op_q};
            W_STAGE:   rdata = {36'd0, stg_wt_q, 4'd0, stg_res_q};
            default:   rdata = '0;
        endcase
    end

    a_r4_load_fills_stage: assert property (@(posedge clk) disable iff (!rst_n)
        load_en |=> (stg_res_q == $past(cur_res)) && (stg_wt_q == $past(cur_wt)));

endmodule

// File: tb/sim_bw_alloc_regs.sv
module sim_bw_alloc_regs;

    localparam int CLK_PERIOD = 10;
    localparam int NRC  = 16;
    localparam int MAXR = 64;
    localparam int BUSY = 3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [5:0]  addr = '0;
    logic [63:0] wdata = '0;
    wire  [63:0] rdata;

    int checks = 0;
    int errors = 0;
    bit done = 0;
    logic [15:0] mres [NRC];
    logic [7:0]  mwt  [NRC];

    bw_alloc_regs u0 (.clk(clk), .rst_n(rst_n), .wr_en(wr_en),
                      .addr(addr), .wdata(wdata), .rdata(rdata));

    always #(CLK_PERIOD/2) clk = ~clk;

    // op(5) rcid(12) res(16) wt(8) expected status(7)
    localparam int NVEC = 12;
    localparam logic [47:0] VEC [NVEC] = '{
        {5'd1,  12'd3,    16'd5,  8'h20, 7'd4},  // over limit
        {5'd1,  12'd0,    16'd40, 8'h10, 7'd1},
        {5'd1,  12'd3,    16'd10, 8'h00, 7'd1},  // exactly at limit
        {5'd1,  12'd5,    16'd2,  8'hff, 7'd4},
        {5'd1,  12'd5,    16'd0,  8'hff, 7'd1},
        {5'd3,  12'd2,    16'd7,  8'h07, 7'd2},
        {5'd0,  12'd2,    16'd7,  8'h07, 7'd2},
        {5'd1,  12'd16,   16'd0,  8'h01, 7'd3},
        {5'd2,  12'd4095, 16'd0,  8'h01, 7'd3},
        {5'd1,  12'd15,   16'd2,  8'h01, 7'd1},
        {5'd2,  12'd3,    16'd9,  8'h55, 7'd1},
        {5'd31, 12'd20,   16'd1,  8'h01, 7'd2}   // opcode checked first
    };

    function automatic logic [63:0] stg(input logic [15:0] r, input logic [7:0] w);
        return {36'd0, w, 4'd0, r};
    endfunction

    function automatic logic [63:0] cmd(input logic [4:0] op, input logic [11:0] id);
        return {44'd0, id, 3'd0, op};
    endfunction

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic summary();
        if (!done) begin
            done = 1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    task automatic wr(input logic [5:0] a, input logic [63:0] d);
        @(negedge clk);
        addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [5:0] a, output logic [63:0] d);
        @(negedge clk);
        addr = a;
        #1 d = rdata;
    endtask

    // count busy cycles from the current negedge, return final status
    task automatic wait_idle(output int n, output logic [6:0] st, output logic [6:0] st_busy);
        n = 0; st_busy = '0;
        addr = 6'd24;
        #1;
        while (rdata[39] && n < 100) begin
            if (n == 0) st_busy = rdata[38:32];
            n++;
            @(negedge clk);
            addr = 6'd24;
            #1;
        end
        st = rdata[38:32];
    endtask

    task automatic run_cmd(input logic [4:0] op, input logic [11:0] id, output logic [6:0] st);
        int n;
        logic [6:0] sb;
        wr(6'd24, cmd(op, id));
        wait_idle(n, st, sb);
        chk("R5 busy length", 64'(n), 64'(BUSY));
        chk("R5 status while busy", 64'(sb), 64'd0);
    endtask

    task automatic expect_stored(input string req, input int id);
        logic [6:0]  st;
        logic [63:0] d;
        run_cmd(5'd2, 12'(id), st);
        chk(req, 64'(st), 64'd1);
        rd(6'd32, d);
        chk(req, d, stg(mres[id], mwt[id]));
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        checks++; errors++;
        $display("FAIL watchdog expired actual=hung expected=finished");
        summary();
    end

    initial begin
        logic [63:0] d;
        logic [6:0]  st;
        int n;
        logic [6:0] sb;

        for (int i = 0; i < NRC; i++) begin
            mres[i] = (i == 0) ? 16'(MAXR - (NRC - 1)) : 16'd1;
            mwt[i]  = 8'd8;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 / R2 / R10: reset state and fixed words
        rd(6'd0, d);  chk("R1 capabilities", d, {16'd0, 16'd64, 8'd0, 16'd256, 4'd1, 4'd0});
        rd(6'd24, d); chk("R2 control after reset", d, 64'd0);
        rd(6'd32, d); chk("R2 staging after reset", d, 64'd0);
        rd(6'd8, d);  chk("R10 monitor control", d, 64'd2 << 32);
        rd(6'd16, d); chk("R10 monitor value", d, 64'd0);
        wr(6'd8, 64'hffff_ffff_ffff_ffff);
        wr(6'd16, 64'hffff_ffff_ffff_ffff);
        wr(6'd0, 64'h0);
        rd(6'd8, d);  chk("R10 monitor control after write", d, 64'd2 << 32);
        rd(6'd16, d); chk("R10 monitor value after write", d, 64'd0);
        rd(6'd0, d);  chk("R1 capabilities after write", d, {16'd0, 16'd64, 8'd0, 16'd256, 4'd1, 4'd0});
        expect_stored("R2 seed rcid0", 0);
        expect_stored("R2 seed rcid7", 7);

        // R4 sentinel: staging is fully replaced by a load
        wr(6'd32, 64'hffff_ffff_ffff_ffff);
        rd(6'd32, d); chk("R3 staging field mask", d, 64'h0000_0000_0ff0_ffff);
        expect_stored("R4 sentinel overwritten", 15);

        // vector table: R3 R7 R8 R9
        for (int v = 0; v < NVEC; v++) begin
            logic [4:0]  op  = VEC[v][47:43];
            logic [11:0] id  = VEC[v][42:31];
            logic [15:0] r   = VEC[v][30:15];
            logic [7:0]  w   = VEC[v][14:7];
            logic [6:0]  es  = VEC[v][6:0];
            wr(6'd32, stg(r, w));
            run_cmd(op, id, st);
            chk($sformatf("R3/R7/R8/R9 status vec %0d", v), 64'(st), 64'(es));
            if (op == 5'd1 && es == 7'd1) begin
                mres[id] = r; mwt[id] = w;
            end
            if (id < NRC) expect_stored($sformatf("R9 storage after vec %0d", v), int'(id));
        end

        // R3 read-modify-commit of the weight keeps the reserved count
        run_cmd(5'd2, 12'd3, st);
        rd(6'd32, d);
        wr(6'd32, stg(d[15:0], 8'hc3));
        run_cmd(5'd1, 12'd3, st);
        chk("R3 modify commit status", 64'(st), 64'd1);
        mwt[3] = 8'hc3;
        expect_stored("R3 other field preserved", 3);

        // R6 control write while busy is ignored
        wr(6'd24, cmd(5'd2, 12'd4));
        wr(6'd24, cmd(5'd1, 12'd0));
        wait_idle(n, st, sb);
        chk("R6 final status", 64'(st), 64'd1);
        rd(6'd24, d);
        chk("R6 latched command", {d[19:8], 3'd0, d[4:0]}, {12'd4, 3'd0, 5'd2});
        rd(6'd32, d);
        chk("R6 staging from first command", d, stg(mres[4], mwt[4]));
        expect_stored("R6 rcid0 untouched", 0);

        summary();
    end

endmodule